// File: doc/BRIEF.md
# Write Leveling Stage Sequencer

This block is the controller-side sequencer for the write leveling step of DRAM training. On a start pulse it sends a mode register write that sets the write leveling bit. After a fixed settle wait it raises the leveling enable toward the PHY. It then emits a one-cycle strobe at a fixed period and watches the PHY's response line in the cycles between strobes. When the response arrives, it sends the mode register write that clears the bit. After the same settle wait it lowers the enable and raises a done flag. The done flag stays high until the next start.

The mode register that is targeted depends on the memory type selected at start. The first mode register receives the command for the two desktop DRAM families, and the second mode register receives it for the low-power family. If no response comes within a set number of strobes, the sequencer drops the enable and parks in an error state. In fast-simulation mode the PHY never answers, so the sequencer skips the stage entirely. It then reports done together with a bypass flag, which tells the training controller to also skip both read training steps.

Top module: `wrlvlSeq`

## Requirements
- R1: The command bank is 1 when `memSel` was 2'b00 or 2'b01 at start, and 2 when it was 2'b10 or 2'b11. The value is latched at the accepted start. `cmdBank` is 0 whenever `cmdValid` is low.
- R2: In the cycle after an accepted non-bypass start, `cmdValid` is high for exactly one cycle. In that cycle `cmdAddr` has only bit `WL_BIT` set. `cmdAddr` is 0 whenever `cmdValid` is low.
- R3: `lvlEnable` rises `MRS_WAIT` cycles after the entry command cycle. It rises in the same cycle as the first strobe.
- R4: While leveling, `lvlStrobe` is a one-cycle pulse. Pulses are exactly `STROBE_PERIOD` cycles apart, and `lvlEnable` is high during every pulse.
- R5: `phyResp` is honoured only in the `STROBE_PERIOD`-1 cycles that follow each strobe. A high response in a strobe cycle, or outside the leveling window, has no effect.
- R6: The cycle after a response is honoured, an exit command is sent with `cmdAddr` equal to 0 and no further strobes follow. `lvlEnable` stays high for `MRS_WAIT` more cycles, then falls in the same cycle that `done` rises. `done` holds until the next accepted start.
- R7: A start pulse that arrives while a sequence is running is ignored.
- R8: If no response is honoured by the end of the window after strobe number `MAX_STROBES`, the sequencer enters error in the next cycle. In error, `error` is high and `lvlEnable` is low, and no exit command is sent. `error` holds until the next start.
- R9: An accepted start with `fastSim` high sends no command and raises `done` and `bypassed` in the next cycle. A later start with `fastSim` low clears `bypassed`.
- R10: After reset every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| startPulse | input | 1 | Starts a sequence when idle, done or in error |
| memSel | input | 2 | Memory type: 00/01 desktop families, 10/11 low-power family |
| fastSim | input | 1 | Skip the leveling stage and report a bypass |
| phyResp | input | 1 | Leveling response from the PHY |
| cmdValid | output | 1 | Mode register write command valid |
| cmdAddr | output | ADDR_W | Mode register write data (address bus) |
| cmdBank | output | BANK_W | Mode register index (bank bus) |
| lvlEnable | output | 1 | Write leveling enable toward the PHY |
| lvlStrobe | output | 1 | Write leveling strobe pulse |
| done | output | 1 | Stage finished or bypassed |
| error | output | 1 | No response within the strobe budget |
| bypassed | output | 1 | The last accepted start skipped the stage |

## Verification
The bench targets several edge cases:
- A response that lands exactly on a strobe cycle, which a design sampling every cycle would wrongly accept.
- A response in the very last cycle of the final window, which a design that let the timeout win would turn into an error.
- A start pulse injected mid-run, which a design that restarts would answer with a second entry command.
- The reserved memory code, which a design would send to the wrong mode register.

A run that times out and is then restarted from error, and a bypass followed by a normal run, catch designs whose flags are sticky in the wrong direction.

// File: rtl/wrlvlPkg.sv
package wrlvlPkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_MRS_ENTER,
    ST_WAIT_MRS,
    ST_STROBE,
    ST_WAIT_RESP,
    ST_MRS_EXIT,
    ST_DONE,
    ST_ERROR
  } seqStateT;

  typedef struct packed {
    logic latchCfg;
    logic loadWait;
    logic loadPeriod;
    logic incStrobe;
    logic clrStrobe;
    logic setEnable;
    logic clrEnable;
    logic setBypass;
    logic clrBypass;
    logic issueEnter;
    logic issueExit;
  } ctlStrobesT;

endpackage

// File: rtl/wrlvlDatapath.sv
module wrlvlDatapath
  import wrlvlPkg::*;
#(
  parameter int ADDR_W        = 14,
  parameter int BANK_W        = 3,
  parameter int WL_BIT        = 7,
  parameter int MRS_WAIT      = 16,
  parameter int STROBE_PERIOD = 8,
  parameter int MAX_STROBES   = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobesT        ctl,
  input  logic [1:0]        memSel,
  output logic              cntZero,
  output logic              lastStrobe,
  output logic              cmdValid,
  output logic [ADDR_W-1:0] cmdAddr,
  output logic [BANK_W-1:0] cmdBank,
  output logic              lvlEnable,
  output logic              bypassed
);

  localparam int CNT_MAX = (MRS_WAIT > STROBE_PERIOD) ? MRS_WAIT : STROBE_PERIOD;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);
  localparam int SCNT_W  = $clog2(MAX_STROBES + 1);
  localparam logic [BANK_W-1:0] BANK_MR1 = BANK_W'(1);
  localparam logic [BANK_W-1:0] BANK_MR2 = BANK_W'(2);

  logic [CNT_W-1:0]  cnt;
  logic [SCNT_W-1:0] strobeCnt;
  logic              useMr2;
  logic              enableQ;
  logic              bypassQ;

  // shared down-counter: settle wait after a command, gap between strobes
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              cnt <= '0;
    else if (ctl.loadWait)  cnt <= CNT_W'(MRS_WAIT - 1);
    else if (ctl.loadPeriod) cnt <= CNT_W'(STROBE_PERIOD - 2);
    else if (cnt != '0)     cnt <= cnt - 1'b1;
  end
  assign cntZero = (cnt == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              strobeCnt <= '0;
    else if (ctl.clrStrobe) strobeCnt <= '0;
    else if (ctl.incStrobe) strobeCnt <= strobeCnt + 1'b1;
  end
  assign lastStrobe = (strobeCnt == SCNT_W'(MAX_STROBES));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) useMr2 <= 1'b0;
    else if (ctl.latchCfg) begin
      case (memSel)
        2'b00, 2'b01: useMr2 <= 1'b0;
        default:      useMr2 <= 1'b1;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              enableQ <= 1'b0;
    else if (ctl.setEnable) enableQ <= 1'b1;
    else if (ctl.clrEnable) enableQ <= 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              bypassQ <= 1'b0;
    else if (ctl.setBypass) bypassQ <= 1'b1;
    else if (ctl.clrBypass) bypassQ <= 1'b0;
  end

  always_comb begin
    cmdValid = ctl.issueEnter | ctl.issueExit;
    cmdAddr  = ctl.issueEnter ? (ADDR_W'(1) << WL_BIT) : '0;
    cmdBank  = cmdValid ? (useMr2 ? BANK_MR2 : BANK_MR1) : '0;
  end

  assign lvlEnable = enableQ;
  assign bypassed  = bypassQ;

endmodule

// File: rtl/wrlvlCtrl.sv
module wrlvlCtrl
  import wrlvlPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       startPulse,
  input  logic       fastSim,
  input  logic       phyResp,
  input  logic       cntZero,
  input  logic       lastStrobe,
  output ctlStrobesT ctl,
  output logic       lvlStrobe,
  output logic       done,
  output logic       error
);

  seqStateT state, stateNext;
  logic     exitPhase, exitPhaseNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      exitPhase <= 1'b0;
    end else begin
      state     <= stateNext;
      exitPhase <= exitPhaseNext;
    end
  end

  always_comb begin
    stateNext     = state;
    exitPhaseNext = exitPhase;
    ctl           = '0;
    unique case (state)
      ST_IDLE, ST_DONE, ST_ERROR: begin
        if (startPulse) begin
          ctl.latchCfg  = 1'b1;
          ctl.clrStrobe = 1'b1;
          if (fastSim) begin
            ctl.setBypass = 1'b1;
            stateNext     = ST_DONE;
          end else begin
            ctl.clrBypass = 1'b1;
            stateNext     = ST_MRS_ENTER;
          end
        end
      end
      ST_MRS_ENTER: begin
        ctl.issueEnter = 1'b1;
        ctl.loadWait   = 1'b1;
        exitPhaseNext  = 1'b0;
        stateNext      = ST_WAIT_MRS;
      end
      ST_WAIT_MRS: begin
        if (cntZero) begin
          if (exitPhase) begin
            ctl.clrEnable = 1'b1;
            stateNext     = ST_DONE;
          end else begin
            ctl.setEnable = 1'b1;
            stateNext     = ST_STROBE;
          end
        end
      end
      ST_STROBE: begin
        ctl.incStrobe  = 1'b1;
        ctl.loadPeriod = 1'b1;
        stateNext      = ST_WAIT_RESP;
      end
      ST_WAIT_RESP: begin
        if (phyResp) begin
          stateNext = ST_MRS_EXIT;
        end else if (cntZero) begin
          if (lastStrobe) begin
            ctl.clrEnable = 1'b1;
            stateNext     = ST_ERROR;
          end else begin
            stateNext = ST_STROBE;
          end
        end
      end
      ST_MRS_EXIT: begin
        ctl.issueExit = 1'b1;
        ctl.loadWait  = 1'b1;
        exitPhaseNext = 1'b1;
        stateNext     = ST_WAIT_MRS;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  assign lvlStrobe = (state == ST_STROBE);
  assign done      = (state == ST_DONE);
  assign error     = (state == ST_ERROR);

endmodule

// File: rtl/wrlvlSeq.sv
module wrlvlSeq
  import wrlvlPkg::*;
#(
  parameter int ADDR_W        = 14,
  parameter int BANK_W        = 3,
  parameter int WL_BIT        = 7,
  parameter int MRS_WAIT      = 16,
  parameter int STROBE_PERIOD = 8,
  parameter int MAX_STROBES   = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startPulse,
  input  logic [1:0]        memSel,
  input  logic              fastSim,
  input  logic              phyResp,
  output logic              cmdValid,
  output logic [ADDR_W-1:0] cmdAddr,
  output logic [BANK_W-1:0] cmdBank,
  output logic              lvlEnable,
  output logic              lvlStrobe,
  output logic              done,
  output logic              error,
  output logic              bypassed
);

  ctlStrobesT ctl;
  logic       cntZero;
  logic       lastStrobe;

  wrlvlCtrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .startPulse (startPulse),
    .fastSim    (fastSim),
    .phyResp    (phyResp),
    .cntZero    (cntZero),
    .lastStrobe (lastStrobe),
    .ctl        (ctl),
    .lvlStrobe  (lvlStrobe),
    .done       (done),
    .error      (error)
  );

  wrlvlDatapath #(
    .ADDR_W        (ADDR_W),
    .BANK_W        (BANK_W),
    .WL_BIT        (WL_BIT),
    .MRS_WAIT      (MRS_WAIT),
    .STROBE_PERIOD (STROBE_PERIOD),
    .MAX_STROBES   (MAX_STROBES)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .ctl        (ctl),
    .memSel     (memSel),
    .cntZero    (cntZero),
    .lastStrobe (lastStrobe),
    .cmdValid   (cmdValid),
    .cmdAddr    (cmdAddr),
    .cmdBank    (cmdBank),
    .lvlEnable  (lvlEnable),
    .bypassed   (bypassed)
  );

endmodule

// File: rtl/wrlvlChecker.sv
module wrlvlChecker #(
  parameter int ADDR_W = 14,
  parameter int BANK_W = 3,
  parameter int WL_BIT = 7
) (
  input logic              clk,
  input logic              rstN,
  input logic              startPulse,
  input logic              cmdValid,
  input logic [ADDR_W-1:0] cmdAddr,
  input logic [BANK_W-1:0] cmdBank,
  input logic              lvlEnable,
  input logic              lvlStrobe,
  input logic              done,
  input logic              error,
  input logic              bypassed
);

  assert_bank_legal_R1: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |-> (cmdBank == BANK_W'(1) || cmdBank == BANK_W'(2)));

  assert_cmd_single_R2: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |=> !cmdValid);

  assert_enter_addr_R2: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && !lvlEnable) |-> (cmdAddr == (ADDR_W'(1) << WL_BIT)));

  assert_strobe_enabled_R3: assert property (@(posedge clk) disable iff (!rstN)
    lvlStrobe |-> lvlEnable);

  assert_strobe_pulse_R4: assert property (@(posedge clk) disable iff (!rstN)
    lvlStrobe |=> !lvlStrobe);

  assert_exit_addr_R6: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && lvlEnable) |-> (cmdAddr == '0));

  assert_done_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    (done && !startPulse) |=> done);

  assert_error_quiet_R8: assert property (@(posedge clk) disable iff (!rstN)
    error |-> (!lvlEnable && !done && !cmdValid));

  assert_bypass_quiet_R9: assert property (@(posedge clk) disable iff (!rstN)
    bypassed |-> (!cmdValid && !lvlEnable && !lvlStrobe));

endmodule

bind wrlvlSeq wrlvlChecker #(
  .ADDR_W (ADDR_W),
  .BANK_W (BANK_W),
  .WL_BIT (WL_BIT)
) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .startPulse (startPulse),
  .cmdValid   (cmdValid),
  .cmdAddr    (cmdAddr),
  .cmdBank    (cmdBank),
  .lvlEnable  (lvlEnable),
  .lvlStrobe  (lvlStrobe),
  .done       (done),
  .error      (error),
  .bypassed   (bypassed)
);

// File: tb/tb_wrlvlSeq.sv
`timescale 1ns/100ps
module tb_wrlvlSeq;

  localparam int ADDR_W = 14;
  localparam int BANK_W = 3;
  localparam int WL_BIT = 7;
  localparam int W      = 3;
  localparam int N      = 4;
  localparam int M      = 5;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic              rstN = 1'b0;
  logic              startPulse = 1'b0;
  logic [1:0]        memSel = 2'b00;
  logic              fastSim = 1'b0;
  logic              phyResp = 1'b0;
  logic              cmdValid;
  logic [ADDR_W-1:0] cmdAddr;
  logic [BANK_W-1:0] cmdBank;
  logic              lvlEnable, lvlStrobe, done, error, bypassed;

  wrlvlSeq #(
    .ADDR_W(ADDR_W), .BANK_W(BANK_W), .WL_BIT(WL_BIT),
    .MRS_WAIT(W), .STROBE_PERIOD(N), .MAX_STROBES(M)
  ) dut (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .memSel(memSel),
    .fastSim(fastSim), .phyResp(phyResp), .cmdValid(cmdValid),
    .cmdAddr(cmdAddr), .cmdBank(cmdBank), .lvlEnable(lvlEnable),
    .lvlStrobe(lvlStrobe), .done(done), .error(error), .bypassed(bypassed)
  );

  int errs = 0;
  int checks = 0;
  bit checking = 1'b0;
  string scen = "R10";

  // reference model: 0 idle, 1 running, 2 done, 3 error
  int mode = 0;
  int t = 0;
  int exitAt = -1;
  bit byp = 1'b0;
  int bankExp = 1;
  int respA = -1;
  int respB = -1;

  function automatic bit inWindow(int tt);
    return (tt >= W + 1) && (tt < W + 1 + M * N);
  endfunction

  function automatic bit isStrobeSlot(int tt);
    return inWindow(tt) && (((tt - W - 1) % N) == 0);
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mode = 0; t = 0; exitAt = -1; byp = 1'b0;
    end else if (startPulse && mode != 1) begin
      if (fastSim) begin
        mode = 2; byp = 1'b1;
      end else begin
        mode = 1; t = 0; exitAt = -1; byp = 1'b0;
        bankExp = memSel[1] ? 2 : 1;
      end
    end else if (mode == 1) begin
      if (exitAt < 0 && phyResp && inWindow(t) && !isStrobeSlot(t)) exitAt = t + 1;
      t = t + 1;
      if (exitAt >= 0 && t == exitAt + W + 1) mode = 2;
      else if (exitAt < 0 && t == W + 1 + M * N) mode = 3;
    end
  end

  task automatic chk(string tag, string name, int act, int exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s/%s %s actual=%0d expected=%0d at t=%0d", tag, scen, name, act, exp, t);
    end
  endtask

  always @(negedge clk) begin
    int eValid, eAddr, eBank, eEn, eStb;
    phyResp = (mode == 1) && (t == respA || t == respB);
    if (rstN && checking) begin
      eValid = (mode == 1) && (t == 0 || t == exitAt);
      eAddr  = (mode == 1 && t == 0) ? (1 << WL_BIT) : 0;
      eBank  = eValid ? bankExp : 0;
      eEn    = (mode == 1) && (t >= W + 1);
      eStb   = (mode == 1) && (exitAt < 0) && isStrobeSlot(t);
      chk("R2", "cmdValid", int'(cmdValid), eValid);
      chk("R2", "cmdAddr", int'(cmdAddr), eAddr);
      chk("R1", "cmdBank", int'(cmdBank), eBank);
      chk("R3", "lvlEnable", int'(lvlEnable), eEn);
      chk("R4", "lvlStrobe", int'(lvlStrobe), eStb);
      chk("R6", "done", int'(done), int'(mode == 2));
      chk("R8", "error", int'(error), int'(mode == 3));
      chk("R9", "bypassed", int'(bypassed), int'(byp));
    end
  end

  task automatic go(logic [1:0] ms, bit fs);
    @(negedge clk);
    memSel = ms; fastSim = fs; startPulse = 1'b1;
    @(negedge clk);
    startPulse = 1'b0; fastSim = 1'b0;
  endtask

  task automatic settle();
    do @(negedge clk); while (mode == 1);
    repeat (3) @(negedge clk);
  endtask

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      errs++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R10: all outputs low after reset
    chk("R10", "outputs", int'({cmdValid, cmdAddr, cmdBank, lvlEnable, lvlStrobe, done, error, bypassed}), 0);
    checking = 1'b1;
    repeat (2) @(negedge clk);

    scen = "R6"; respA = 10; respB = -1;       // desktop type, normal finish
    go(2'b00, 1'b0); settle();

    scen = "R5"; respA = 8; respB = 14;         // t=8 is a strobe slot, ignored
    go(2'b10, 1'b0); settle();

    scen = "R5"; respA = 2; respB = 23;         // before window ignored; last slot honoured
    go(2'b01, 1'b0); settle();

    scen = "R8"; respA = -1; respB = 24;        // no response in window: timeout
    go(2'b00, 1'b0); settle();
    chk("R8", "error", int'(error), 1);

    scen = "R7"; respA = 17; respB = -1;        // restart from error, mid-run start ignored
    go(2'b11, 1'b0);
    repeat (6) @(negedge clk);
    startPulse = 1'b1; fastSim = 1'b1; memSel = 2'b00;
    @(negedge clk);
    startPulse = 1'b0; fastSim = 1'b0;
    settle();
    chk("R7", "bypassed", int'(bypassed), 0);

    scen = "R9"; respA = -1; respB = -1;        // bypass from done
    go(2'b00, 1'b1); settle();
    chk("R9", "bypassed", int'(bypassed), 1);

    scen = "R9"; respA = 5;                     // normal start clears bypass
    go(2'b10, 1'b0); settle();
    chk("R9", "bypassed", int'(bypassed), 0);

    scen = "R1"; respA = 9;
    go(2'b01, 1'b0); settle();

    checking = 1'b0;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule